// File: doc/BRIEF.md
# CCD Horizontal Timing Generator

This block produces the per-pixel drive waveforms for a CCD area sensor. A line counter advances on every master clock and is forced back to zero by the rising edge of a horizontal reference input. The count is decoded into a two-phase horizontal transfer clock, two secondary transfer outputs, a reset gate pulse, a clamp pulse for correlated double sampling and a sample-hold pulse. Each pixel lasts four master clocks. Every drive output comes from a flip-flop.

Four static strap inputs set the operating mode. They select the TV standard, which fixes the line length. They select the sensor type, which sets the pulse slots and the blanking window. They select normal or mirror readout, which swaps the secondary transfer outputs. They select fixed or adjustable sampling phase. In the adjustable mode the internal clamp and sample-hold pulses leave on tap outputs, pass through an external delay network and come back on return inputs. The board holds open straps high, so PAL, mirror, type B and fixed phase are the defaults.

Top module: `ccd_htg`

## Requirements
- R1: With `pal_i` low and no reference edge, the line counter steps 0 to 1211 and wraps, so the line repeats every 1212 clocks.
- R2: With `pal_i` high and no reference edge, the line repeats every 1236 clocks.
- R3: A rising edge on `hd_i` (high now, low at the previous edge) loads count 0 at that clock edge. The outputs decoded from count 0 appear one edge later. Holding `hd_i` high causes no further reload.
- R4: Outside blanking, `fh1_o` is high for the sub-phases 0 and 1 (count mod 4) and low for 2 and 3. `fh2_o` is always the inverse of `fh1_o` after reset.
- R5: For counts lo <= count < hi, the transfer clocks idle with `fh1_o`=1 and `fh2_o`=0. lo is 4. hi is 120 for NTSC type A, 116 for NTSC type B, 124 for PAL type A and 120 for PAL type B.
- R6: With `mirror_i` low, `fh1b_o` follows `fh1_o` and `fh2b_o` follows `fh2_o`.
- R7: With `mirror_i` high, `fh1b_o` follows `fh2_o` and `fh2b_o` follows `fh1_o`.
- R8: Once per pixel, `rg_o`, `cds_tap_o` and `sh_tap_o` each go high for one clock, in that order and never together. With `sens_b_i` low (type A) they occupy sub-phases 0, 1 and 2. With it high (type B) they occupy sub-phases 1, 2 and 3.
- R9: With `fixph_i` high, `sh_o` and `cds_o` equal `sh_tap_o` and `cds_tap_o`, and the return inputs have no effect.
- R10: With `fixph_i` low, `sh_o` follows `sh_ret_i` and `cds_o` follows `cds_ret_i` in the same cycle.
- R11: While `rst_ni` is low, every registered output is low and the count is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Horizontal reference; its rising edge restarts the line |
| pal_i | input | 1 | 0 selects NTSC (1212 clocks), 1 selects PAL (1236 clocks) |
| sens_b_i | input | 1 | 0 selects type A sensor timing, 1 selects type B |
| mirror_i | input | 1 | 0 selects normal readout, 1 selects mirror readout |
| fixph_i | input | 1 | 1 selects fixed sampling phase, 0 selects the external delay path |
| sh_ret_i | input | 1 | Delayed sample-hold timing returned from the external network |
| cds_ret_i | input | 1 | Delayed clamp timing returned from the external network |
| fh1_o | output | 1 | Horizontal transfer clock, phase 1 |
| fh2_o | output | 1 | Horizontal transfer clock, phase 2 |
| fh1b_o | output | 1 | Secondary transfer clock 1 |
| fh2b_o | output | 1 | Secondary transfer clock 2 |
| rg_o | output | 1 | Reset gate pulse |
| sh_tap_o | output | 1 | Internal sample-hold timing sent to the delay network |
| cds_tap_o | output | 1 | Internal clamp timing sent to the delay network |
| sh_o | output | 1 | Sample-hold pulse |
| cds_o | output | 1 | Clamp pulse |

## Verification
The natural line wrap and a reference-edge reload can fall in the same clock. The bench provokes this by raising `hd_i` exactly when its own count model holds the last count of the line, in both standards. The result is judged in two ways. The first long high run of `fh1_o`, which marks entry into blanking, must appear exactly seven clocks after the reload edge. The next marker must follow exactly one line length later, so the collision neither adds nor drops a clock. A second overlap is a reference edge that arrives in the middle of a pixel. It is driven at sub-phase 2 in every mode combination, and the outputs are compared every cycle with an arithmetic model of the count.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

  typedef struct packed {
    int unsigned lo;
    int unsigned hi;
  } win_t;

  typedef struct packed {
    int unsigned rg;
    int unsigned cds;
    int unsigned sh;
  } slot_t;

  // transfer clocks idle over [lo, hi)
  function automatic win_t blank_win(logic pal, logic typ_b);
    win_t w;
    w.lo = 4;
    case ({pal, typ_b})
      2'b00:   w.hi = 120;
      2'b01:   w.hi = 116;
      2'b10:   w.hi = 124;
      default: w.hi = 120;
    endcase
    return w;
  endfunction

  // sampling sub-phases: reset, then clamp, then sample-hold
  function automatic slot_t pulse_slots(logic typ_b);
    slot_t s;
    if (typ_b) begin
      s.rg = 1; s.cds = 2; s.sh = 3;
    end else begin
      s.rg = 0; s.cds = 1; s.sh = 2;
    end
    return s;
  endfunction

endpackage

// File: rtl/ccd_line_cnt.sv
module ccd_line_cnt #(
  parameter int unsigned LEN_NTSC = 1212,
  parameter int unsigned LEN_PAL  = 1236,
  parameter int unsigned CNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hd_i,
  input  logic             pal_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic             hd_q;
  logic             hd_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  assign last_c  = pal_i ? CNT_W'(LEN_PAL - 1) : CNT_W'(LEN_NTSC - 1);
  assign hd_rise = hd_i & ~hd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hd_q <= hd_i;
      // >= guards a standard switch while beyond the shorter line
      if (hd_rise || cnt_q >= last_c) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_rise |=> cnt_q == '0);

  assert_wrap_ntsc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hd_rise && !pal_i && cnt_q == CNT_W'(LEN_NTSC - 1)) |=> cnt_q == '0);

  assert_wrap_pal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hd_rise && pal_i && cnt_q == CNT_W'(LEN_PAL - 1)) |=> cnt_q == '0);

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hd_rise && cnt_q < last_c) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ccd_pulse_dec.sv
module ccd_pulse_dec
  import ccd_htg_pkg::*;
#(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned PIX_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pal_i,
  input  logic             typ_b_i,
  input  logic             mir_i,
  output logic             fh1_o,
  output logic             fh2_o,
  output logic             fh1b_o,
  output logic             fh2b_o,
  output logic             rg_o,
  output logic             cds_o,
  output logic             sh_o
);

  localparam int unsigned SUB_W = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam int unsigned HALF  = PIX_DIV / 2;

  logic [SUB_W-1:0] sub;
  logic             in_blank;
  logic             fh1_d, fh2_d;
  logic             rg_d, cds_d, sh_d;
  win_t             win;
  slot_t            slt;

  assign sub      = cnt_i[SUB_W-1:0];
  assign win      = blank_win(pal_i, typ_b_i);
  assign slt      = pulse_slots(typ_b_i);
  assign in_blank = (cnt_i >= CNT_W'(win.lo)) && (cnt_i < CNT_W'(win.hi));

  always_comb begin
    fh1_d = in_blank | (sub < SUB_W'(HALF));
    fh2_d = ~fh1_d;
    rg_d  = (sub == SUB_W'(slt.rg));
    cds_d = (sub == SUB_W'(slt.cds));
    sh_d  = (sub == SUB_W'(slt.sh));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fh1_o  <= 1'b0;
      fh2_o  <= 1'b0;
      fh1b_o <= 1'b0;
      fh2b_o <= 1'b0;
      rg_o   <= 1'b0;
      cds_o  <= 1'b0;
      sh_o   <= 1'b0;
    end else begin
      fh1_o  <= fh1_d;
      fh2_o  <= fh2_d;
      fh1b_o <= mir_i ? fh2_d : fh1_d;
      fh2b_o <= mir_i ? fh1_d : fh2_d;
      rg_o   <= rg_d;
      cds_o  <= cds_d;
      sh_o   <= sh_d;
    end
  end

  assert_fh_opposite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (fh1_o != fh2_o));

  assert_pulse_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $onehot0({rg_o, cds_o, sh_o}));

endmodule

// File: rtl/ccd_phase_sel.sv
module ccd_phase_sel (
  input  logic fix_i,
  input  logic sh_int_i,
  input  logic cds_int_i,
  input  logic sh_ret_i,
  input  logic cds_ret_i,
  output logic sh_tap_o,
  output logic cds_tap_o,
  output logic sh_o,
  output logic cds_o
);

  assign sh_tap_o  = sh_int_i;
  assign cds_tap_o = cds_int_i;
  // adjustable phase: the external RC path closes the loop combinationally
  assign sh_o      = fix_i ? sh_int_i  : sh_ret_i;
  assign cds_o     = fix_i ? cds_int_i : cds_ret_i;

endmodule

// File: rtl/ccd_htg.sv
module ccd_htg #(
  parameter int unsigned LEN_NTSC = 1212,
  parameter int unsigned LEN_PAL  = 1236,
  parameter int unsigned PIX_DIV  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_i,
  input  logic pal_i,
  input  logic sens_b_i,
  input  logic mirror_i,
  input  logic fixph_i,
  input  logic sh_ret_i,
  input  logic cds_ret_i,
  output logic fh1_o,
  output logic fh2_o,
  output logic fh1b_o,
  output logic fh2b_o,
  output logic rg_o,
  output logic sh_tap_o,
  output logic cds_tap_o,
  output logic sh_o,
  output logic cds_o
);

  localparam int unsigned LEN_MAX = (LEN_PAL > LEN_NTSC) ? LEN_PAL : LEN_NTSC;
  localparam int unsigned CNT_W   = $clog2(LEN_MAX);

  logic [CNT_W-1:0] cnt;
  logic             cds_int, sh_int;

  ccd_line_cnt #(
    .LEN_NTSC (LEN_NTSC),
    .LEN_PAL  (LEN_PAL),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hd_i   (hd_i),
    .pal_i  (pal_i),
    .cnt_o  (cnt)
  );

  ccd_pulse_dec #(
    .CNT_W   (CNT_W),
    .PIX_DIV (PIX_DIV)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .pal_i   (pal_i),
    .typ_b_i (sens_b_i),
    .mir_i   (mirror_i),
    .fh1_o   (fh1_o),
    .fh2_o   (fh2_o),
    .fh1b_o  (fh1b_o),
    .fh2b_o  (fh2b_o),
    .rg_o    (rg_o),
    .cds_o   (cds_int),
    .sh_o    (sh_int)
  );

  ccd_phase_sel u_sel (
    .fix_i     (fixph_i),
    .sh_int_i  (sh_int),
    .cds_int_i (cds_int),
    .sh_ret_i  (sh_ret_i),
    .cds_ret_i (cds_ret_i),
    .sh_tap_o  (sh_tap_o),
    .cds_tap_o (cds_tap_o),
    .sh_o      (sh_o),
    .cds_o     (cds_o)
  );

  assert_normal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !mirror_i) |=> (fh1b_o == fh1_o && fh2b_o == fh2_o));

  assert_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && mirror_i) |=> (fh1b_o == fh2_o && fh2b_o == fh1_o));

endmodule

// File: tb/ccd_htg_tb.sv
module ccd_htg_tb;

  localparam int CLK_T = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hd_i = 1'b0;
  logic pal_i = 1'b0, sens_b_i = 1'b0, mirror_i = 1'b0, fixph_i = 1'b1;
  logic sh_ret_i = 1'b0, cds_ret_i = 1'b0;
  logic fh1_o, fh2_o, fh1b_o, fh2b_o, rg_o, sh_tap_o, cds_tap_o, sh_o, cds_o;

  int n_chk = 0;
  int n_bad = 0;
  int mc = 0;
  bit mhd = 1'b0;
  int cyc = 0;

  // marker tracking for line period checks
  int  hi_run = 0;
  int  last_mark = 0;
  bit  mark_ok = 1'b0;
  bit  armed = 1'b0;
  int  rise_cyc = 0;
  logic [1:0] prev_mode = 2'b00;

  always #(CLK_T/2) clk_i = ~clk_i;

  ccd_htg u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hd_i      (hd_i),
    .pal_i     (pal_i),
    .sens_b_i  (sens_b_i),
    .mirror_i  (mirror_i),
    .fixph_i   (fixph_i),
    .sh_ret_i  (sh_ret_i),
    .cds_ret_i (cds_ret_i),
    .fh1_o     (fh1_o),
    .fh2_o     (fh2_o),
    .fh1b_o    (fh1b_o),
    .fh2b_o    (fh2b_o),
    .rg_o      (rg_o),
    .sh_tap_o  (sh_tap_o),
    .cds_tap_o (cds_tap_o),
    .sh_o      (sh_o),
    .cds_o     (cds_o)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d got=%0d exp=%0d", tag, cyc, got, exp);
    end
  endtask

  function automatic int line_len(bit pal);
    return pal ? 1236 : 1212;
  endfunction

  function automatic bit in_blank(int c, bit pal, bit typ);
    int hi;
    hi = pal ? (typ ? 120 : 124) : (typ ? 116 : 120);
    return (c >= 4) && (c < hi);
  endfunction

  // per-cycle reference model and comparison
  always @(posedge clk_i) begin
    bit e_fh1, e_fh2, e_b1, e_b2, e_rg, e_cds, e_sh, blk, rise, r_ok, p, t, m, f;
    int sub;
    cyc++;
    p = pal_i; t = sens_b_i; m = mirror_i; f = fixph_i;
    r_ok = rst_ni;
    rise = 1'b0;
    blk = 1'b0;
    if (!r_ok) begin
      mc = 0; mhd = 1'b0;
      {e_fh1, e_fh2, e_b1, e_b2, e_rg, e_cds, e_sh} = '0;
    end else begin
      sub   = mc % 4;
      blk   = in_blank(mc, p, t);
      e_fh1 = blk || (sub < 2);
      e_fh2 = !e_fh1;
      e_b1  = m ? e_fh2 : e_fh1;
      e_b2  = m ? e_fh1 : e_fh2;
      e_rg  = (sub == (t ? 1 : 0));
      e_cds = (sub == (t ? 2 : 1));
      e_sh  = (sub == (t ? 3 : 2));
      rise  = hd_i && !mhd;
      mhd   = hd_i;
      if (rise || mc >= line_len(p) - 1) mc = 0;
      else mc = mc + 1;
    end
    #3;
    if (!r_ok) begin
      chk("R11 fh1", fh1_o, 0);
      chk("R11 fh2", fh2_o, 0);
      chk("R11 fhb", {fh1b_o, fh2b_o}, 0);
      chk("R11 pulses", {rg_o, cds_tap_o, sh_tap_o}, 0);
      hi_run = 0; mark_ok = 1'b0; armed = 1'b0;
    end else begin
      chk(blk ? "R5 fh1" : "R4 fh1", fh1_o, e_fh1);
      chk(blk ? "R5 fh2" : "R4 fh2", fh2_o, e_fh2);
      chk(m ? "R7 fh1b" : "R6 fh1b", fh1b_o, e_b1);
      chk(m ? "R7 fh2b" : "R6 fh2b", fh2b_o, e_b2);
      chk("R8 rg", rg_o, e_rg);
      chk("R8 cds_tap", cds_tap_o, e_cds);
      chk("R8 sh_tap", sh_tap_o, e_sh);
      chk(f ? "R9 sh" : "R10 sh", sh_o, f ? e_sh : sh_ret_i);
      chk(f ? "R9 cds" : "R10 cds", cds_o, f ? e_cds : cds_ret_i);
      if ({p, t} != prev_mode) mark_ok = 1'b0;
      prev_mode = {p, t};
      if (rise) begin
        armed = 1'b1; rise_cyc = cyc; mark_ok = 1'b0;
      end
      hi_run = fh1_o ? hi_run + 1 : 0;
      if (hi_run == 3) begin
        if (armed) begin
          chk("R3 reload-to-blank", cyc - rise_cyc, 7);
          armed = 1'b0;
        end else if (mark_ok) begin
          chk(p ? "R2 period" : "R1 period", cyc - last_mark, line_len(p));
        end
        last_mark = cyc;
        mark_ok = 1'b1;
      end
    end
  end

  task automatic hd_mid_line();
    @(negedge clk_i);
    while (!((mc % 4) == 2 && mc >= 140 && mc < 1100)) @(negedge clk_i);
    hd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    hd_i = 1'b0;
  endtask

  task automatic hd_at_wrap();
    @(negedge clk_i);
    while (mc != line_len(pal_i) - 1) @(negedge clk_i);
    hd_i = 1'b1;
    @(negedge clk_i);
    hd_i = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sh_ret_i  = cyc[0];
      cds_ret_i = cyc[1] ^ cyc[0];
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_T * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    run(5);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(20);
    // sweep every mode combination
    for (int md = 0; md < 16; md++) begin
      @(negedge clk_i);
      {fixph_i, mirror_i, sens_b_i, pal_i} = 4'(md);
      hd_mid_line();
      run(2600);
    end
    // reference edge coincident with the natural wrap
    fixph_i = 1'b1; mirror_i = 1'b0; sens_b_i = 1'b0;
    pal_i = 1'b0;
    run(1300);
    hd_at_wrap();
    run(2600);
    pal_i = 1'b1;
    run(1300);
    hd_at_wrap();
    run(2600);
    // reset in mid run
    @(negedge clk_i);
    rst_ni = 1'b0;
    run(3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(30);
    finish_up();
  end

endmodule